// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM with a 16-bit data path split into two byte lanes. A requester presents a word address, a read/write flag, write data and a two-bit lane mask with a valid/ready handshake. The controller then plays out one complete memory cycle on the RAM pins. It selects the part through two chip selects of opposite polarity, drives the write strobe, the output enable and the two active-low lane strobes, and controls a split data bus: separate in and out vectors plus an output enable for the pad driver.

Every timing phase lasts a whole number of clock cycles. Each count is derived at elaboration from the clock period and the speed grade (55 ns or 70 ns) as max(1, ceil(time / period)), so every minimum is met at any clock rate. Between cycles the part is held deselected, which keeps it in its low-power standby state. Read data comes back with a one-cycle valid strobe. Lanes that the mask leaves out read as zero.

Top module: `asramByteCtrl`

## Requirements
- R1: After reset and whenever no cycle is in progress, reqReady is 1, memCe1N is 1, memCe2 is 0, memWeN, memOeN, memBheN and memBleN are all 1, and memDqOe is 0.
- R2: A write request is accepted on a clock edge where reqValid and reqReady are both 1. For the next WP cycles the chip is selected (memCe1N 0, memCe2 1), memWeN is 0 and memOeN is 1. memBleN is the inverse of reqBe[0] and memBheN the inverse of reqBe[1]. memAddr and memDqOut carry the request's address and data, and memDqOe is 1. Then follow WR cycles with the chip deselected and memDqOe 0.
- R3: Phase counts are max(1, ceil(t / CLK_PERIOD_NS)). WP covers the largest of the write-strobe width, address/select setup and lane-strobe setup to write end, and data setup: 40/40/45/25 ns for the 55 ns grade and 45/60/60/30 ns for the 70 ns grade. WR is max(1, ceil(cycle time / period) - WP). With an 8 ns clock and the 55 ns grade, WP is 6 and WR is 1.
- R4: An accepted read selects the chip for RD cycles (RD = count of the access time, 7 at 8 ns / 55 ns). During those cycles memWeN is 1 and memOeN is 0, the lane strobes follow the mask as in R2, and memDqOe stays 0.
- R5: Read data is sampled from memDqIn on the edge that ends the RD phase. rspValid is 1 for exactly the following cycle, and rspData holds the sample there. Bits [7:0] are forced to 0 if reqBe[0] was 0, and bits [15:8] are forced to 0 if reqBe[1] was 0.
- R6: After a read the chip is deselected with memOeN 1 for TA cycles before reqReady returns. TA is the count of the output-float time: 20 ns (55 grade) or 25 ns (70 grade), giving 3 at 8 ns / 55 ns. memDqOe is never 1 until at least TA edges after memOeN went high.
- R7: reqReady is 0 from the edge after acceptance until the cycle's last phase ends. A reqValid presented meanwhile is neither taken nor allowed to change the cycle under way, and it is accepted once reqReady returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request taken this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rspValid | output | 1 | One-cycle read data strobe |
| rspData | output | 16 | Read data, unselected lanes zero |
| memAddr | output | ADDR_W | RAM address pins |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memBheN | output | 1 | Active-low high-lane strobe |
| memBleN | output | 1 | Active-low low-lane strobe |
| memDqOut | output | 16 | Data to the pad drivers |
| memDqOe | output | 1 | Pad driver enable |
| memDqIn | input | 16 | Data from the pads |

## Verification
The pin assertions assume that the requester changes reqAddr, reqWdata, reqBe and reqWrite only while it is not being accepted, and that memDqIn matters only in the RD phase. The bench drives requests on the falling edge and holds them until the reference model sees acceptance. Its RAM model answers only when the chip is selected for a read, and it puts a fixed non-zero pattern on every lane that is not enabled, so lane masking is visible at rspData. The sequences include back-to-back writes, a read followed by a write to exercise the turnaround, all four lane masks and the highest address.

// File: rtl/asramPkg.sv
package asramPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;     // latch a new request
    logic sel;      // chip selected
    logic weAct;    // write strobe active
    logic oeAct;    // output enable active
    logic drive;    // pad drivers on
    logic capture;  // sample read data at this edge
  } ctrlStrobes_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Whole cycles covering ns at the given period, never below one.
  function automatic int cyclesFor(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/asramCtrl.sv
module asramCtrl
  import asramPkg::*;
#(
  parameter int WP_CYC = 6,
  parameter int WR_CYC = 1,
  parameter int RD_CYC = 7,
  parameter int TA_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output ctrlStrobes_t str
);

  localparam int MAXC = maxOf(maxOf(WP_CYC, WR_CYC), maxOf(RD_CYC, TA_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WPULSE, S_WREC, S_RPULSE, S_RTURN
  } phase_t;

  phase_t        state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic          lastCyc;

  assign lastCyc = (cnt == '0);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stateNxt = reqWrite ? S_WPULSE : S_RPULSE;
          cntNxt   = reqWrite ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
        end
      end
      S_WPULSE: begin
        if (lastCyc) begin
          stateNxt = S_WREC;
          cntNxt   = CW'(WR_CYC - 1);
        end else cntNxt = cnt - 1'b1;
      end
      S_WREC: begin
        if (lastCyc) stateNxt = S_IDLE;
        else cntNxt = cnt - 1'b1;
      end
      S_RPULSE: begin
        if (lastCyc) begin
          stateNxt = S_RTURN;
          cntNxt   = CW'(TA_CYC - 1);
        end else cntNxt = cnt - 1'b1;
      end
      S_RTURN: begin
        if (lastCyc) stateNxt = S_IDLE;
        else cntNxt = cnt - 1'b1;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    reqReady    = (state == S_IDLE);
    str.load    = reqReady && reqValid;
    str.sel     = (state == S_WPULSE) || (state == S_RPULSE);
    str.weAct   = (state == S_WPULSE);
    str.drive   = (state == S_WPULSE);
    str.oeAct   = (state == S_RPULSE);
    str.capture = (state == S_RPULSE) && lastCyc;
  end

  // R7: once a request is taken the handshake closes on the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    str.load |=> !reqReady);

  // R5: a capture is followed by the turnaround, never by another capture
  a_r5_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    str.capture |=> !str.capture);

endmodule

// File: rtl/asramDatapath.sv
module asramDatapath
  import asramPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DW     = 16,
  parameter int WP_CYC = 6,
  parameter int TA_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      str,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [DW/8-1:0]   reqBe,
  output logic              rspValid,
  output logic [DW-1:0]     rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DW/8-1:0]   memLaneN,
  output logic [DW-1:0]     memDqOut,
  output logic              memDqOe,
  input  logic [DW-1:0]     memDqIn
);

  localparam int LANES = DW / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DW-1:0]     wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DW-1:0]     rdMasked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (str.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign memLaneN[g]         = ~(str.sel & beQ[g]);
      assign rdMasked[g*8 +: 8]  = beQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
    end
  endgenerate

  assign memAddr  = addrQ;
  assign memCe1N  = ~str.sel;
  assign memCe2   = str.sel;
  assign memWeN   = ~str.weAct;
  assign memOeN   = ~str.oeAct;
  assign memDqOut = wdataQ;
  assign memDqOe  = str.drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= str.capture;
      if (str.capture) rspData <= rdMasked;
    end
  end

  // Window counters for the timing checks below.
  logic [7:0] weLowCnt;
  logic [7:0] oeHighCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weLowCnt  <= '0;
      oeHighCnt <= 8'hFF;
    end else begin
      if (memWeN) weLowCnt <= '0;
      else if (weLowCnt != 8'hFF) weLowCnt <= weLowCnt + 1'b1;
      if (!memOeN) oeHighCnt <= '0;
      else if (oeHighCnt != 8'hFF) oeHighCnt <= oeHighCnt + 1'b1;
    end
  end

  // R2: a write strobe only inside a selected, driven, output-disabled window
  a_r2_write_framed: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (!memCe1N && memCe2 && memOeN && memDqOe));

  // R3: the write strobe stays low for the full pulse count
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> (weLowCnt >= 8'(WP_CYC)));

  // R4: pads never driven while the RAM may be driving
  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |-> !memDqOe);

  // R6: drivers wait out the float time after output enable is released
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    memDqOe |-> (oeHighCnt >= 8'(TA_CYC)));

  // R5: the valid strobe lasts one cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

endmodule

// File: rtl/asramByteCtrl.sv
module asramByteCtrl
  import asramPkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_NS      = 55,
  parameter int ADDR_W        = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqBe,
  output logic              rspValid,
  output logic [15:0]       rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memBheN,
  output logic              memBleN,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);

  localparam bit SLOW     = (SPEED_NS >= 70);
  localparam int T_WE_NS  = SLOW ? 45 : 40;
  localparam int T_AW_NS  = SLOW ? 60 : 40;
  localparam int T_BW_NS  = SLOW ? 60 : 45;
  localparam int T_DS_NS  = SLOW ? 30 : 25;
  localparam int T_WC_NS  = SLOW ? 70 : 55;
  localparam int T_AA_NS  = SLOW ? 70 : 55;
  localparam int T_HZ_NS  = SLOW ? 25 : 20;

  localparam int WP_CYC = cyclesFor(maxOf(maxOf(T_WE_NS, T_AW_NS),
                                          maxOf(T_BW_NS, T_DS_NS)), CLK_PERIOD_NS);
  localparam int WC_CYC = cyclesFor(T_WC_NS, CLK_PERIOD_NS);
  localparam int WR_CYC = maxOf(1, WC_CYC - WP_CYC);
  localparam int RD_CYC = cyclesFor(T_AA_NS, CLK_PERIOD_NS);
  localparam int TA_CYC = cyclesFor(T_HZ_NS, CLK_PERIOD_NS);

  ctrlStrobes_t str;
  logic [1:0]   laneN;

  asramCtrl #(
    .WP_CYC(WP_CYC), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .str(str)
  );

  asramDatapath #(
    .ADDR_W(ADDR_W), .DW(16), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .str(str),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memLaneN(laneN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  assign memBleN = laneN[0];
  assign memBheN = laneN[1];

  // R1: an open handshake means the RAM sits in standby
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (memCe1N && !memCe2 && memWeN && memOeN && !memDqOe));

  // R7: the handshake is closed while the chip is selected
  a_r7_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !memCe1N |-> !reqReady);

endmodule

// File: tb/tb_asramByteCtrl.sv
module tb_asramByteCtrl;

  // Expected counts at 8 ns / 55 ns grade, worked out from R3, R4, R6.
  localparam int EXP_WP = 6;   // ceil(45/8)
  localparam int EXP_WR = 1;   // ceil(55/8)=7, minus 6
  localparam int EXP_RD = 7;   // ceil(55/8)
  localparam int EXP_TA = 3;   // ceil(20/8)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        reqReady, rspValid, memCe1N, memCe2, memWeN, memOeN, memBheN, memBleN, memDqOe;
  logic [15:0] rspData, memDqOut, memDqIn;
  logic [19:0] memAddr;

  asramByteCtrl dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memBheN(memBheN), .memBleN(memBleN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // RAM model: 16 words indexed by the low address bits.
  logic [15:0] bmem [16];
  logic        rdSel;
  assign rdSel = !memCe1N && memCe2 && memWeN && !memOeN;
  always_comb begin
    memDqIn = 16'hA5A5;
    if (rdSel) begin
      if (!memBleN) memDqIn[7:0]  = bmem[memAddr[3:0]][7:0];
      if (!memBheN) memDqIn[15:8] = bmem[memAddr[3:0]][15:8];
    end
  end
  always @(posedge clk) begin
    if (!memCe1N && memCe2 && !memWeN) begin
      if (!memBleN) bmem[memAddr[3:0]][7:0]  <= memDqOut[7:0];
      if (!memBheN) bmem[memAddr[3:0]][15:8] <= memDqOut[15:8];
    end
  end

  // Reference model.
  int          phase;  // 0 idle, 1 write pulse, 2 write recovery, 3 read, 4 turnaround
  int          left;
  logic [19:0] mAddr;
  logic [15:0] mData, expRd;
  logic [1:0]  mBe;
  logic        expRv, accepted;
  logic [15:0] refMem [16];

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    expRv    <= 1'b0;
    accepted <= 1'b0;
    if (!rst_n) begin
      phase <= 0; left <= 0;
    end else begin
      case (phase)
        0: if (reqValid) begin
             mAddr <= reqAddr; mData <= reqWdata; mBe <= reqBe; accepted <= 1'b1;
             if (reqWrite) begin
               phase <= 1; left <= EXP_WP;
               if (reqBe[0]) refMem[reqAddr[3:0]][7:0]  <= reqWdata[7:0];
               if (reqBe[1]) refMem[reqAddr[3:0]][15:8] <= reqWdata[15:8];
             end else begin
               phase <= 3; left <= EXP_RD;
             end
           end
        1: if (left == 1) begin phase <= 2; left <= EXP_WR; end else left <= left - 1;
        2: if (left == 1) phase <= 0; else left <= left - 1;
        3: if (left == 1) begin
             phase <= 4; left <= EXP_TA; expRv <= 1'b1;
             expRd <= {mBe[1] ? refMem[mAddr[3:0]][15:8] : 8'h00,
                       mBe[0] ? refMem[mAddr[3:0]][7:0]  : 8'h00};
           end else left <= left - 1;
        4: if (left == 1) phase <= 0; else left <= left - 1;
        default: phase <= 0;
      endcase
    end
  end

  // Per-cycle comparison on the falling edge.
  int  weLow = 0;
  logic prevWeN = 1'b1;
  always @(negedge clk) begin
    logic [7:0] act, exp;
    logic sel;
    string tag;
    sel = (phase == 1) || (phase == 3);
    exp = {phase == 0, !sel, sel, phase != 1, phase != 3,
           !(sel && mBe[1]), !(sel && mBe[0]), phase == 1};
    act = {reqReady, memCe1N, memCe2, memWeN, memOeN, memBheN, memBleN, memDqOe};
    case (phase)
      0: tag = "R1/R7 idle pins";
      1: tag = "R2 write pulse pins";
      2: tag = "R2 write recovery pins";
      3: tag = "R4 read pins";
      default: tag = "R6 turnaround pins";
    endcase
    if (phase == 0 && rst_n) exp[6:1] = 6'b101111;
    if (phase == 0) begin exp[2] = 1'b1; exp[1] = 1'b1; end
    check(act == exp, tag, {24'h0, act}, {24'h0, exp});
    if (sel) check(memAddr == mAddr, "R2/R4 address", {12'h0, memAddr}, {12'h0, mAddr});
    if (phase == 1) check(memDqOut == mData, "R2 write data", {16'h0, memDqOut}, {16'h0, mData});
    check(rspValid == expRv, "R5 valid pulse", {31'h0, rspValid}, {31'h0, expRv});
    if (expRv) check(rspData == expRd, "R5 read data", {16'h0, rspData}, {16'h0, expRd});
    // R3: length of every write strobe
    if (!memWeN) weLow++;
    if (memWeN && !prevWeN) begin
      check(weLow == EXP_WP, "R3 write strobe cycles", weLow, EXP_WP);
      weLow = 0;
    end
    prevWeN = memWeN;
  end

  task automatic issue(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqBe = be;
    forever begin
      @(posedge clk); #1;
      if (accepted) break;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin bmem[i] = '0; refMem[i] = '0; end
    phase = 0; left = 0; mBe = '0; mAddr = '0; mData = '0; expRd = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R2, R5: full word, then each lane alone, then empty mask
    issue(1'b1, 20'h00001, 16'h1234, 2'b11);
    issue(1'b0, 20'h00001, 16'h0000, 2'b11);
    issue(1'b1, 20'h00002, 16'hBEEF, 2'b11);
    issue(1'b1, 20'h00002, 16'h77C3, 2'b01);
    issue(1'b0, 20'h00002, 16'h0000, 2'b11);
    issue(1'b1, 20'h00002, 16'h9A00, 2'b10);
    issue(1'b0, 20'h00002, 16'h0000, 2'b01);
    issue(1'b0, 20'h00002, 16'h0000, 2'b10);
    issue(1'b1, 20'h00002, 16'hFFFF, 2'b00);
    issue(1'b0, 20'h00002, 16'h0000, 2'b00);
    issue(1'b0, 20'h00002, 16'h0000, 2'b11);
    // R6: read straight into a write, top address
    issue(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
    issue(1'b1, 20'hFFFFF, 16'hC0DE, 2'b11);
    issue(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
    idle(3);
    // R7: mixed back-to-back traffic
    for (int k = 0; k < 60; k++) begin
      issue(1'($urandom_range(0, 1)), 20'($urandom_range(0, 7)),
            16'($urandom), 2'($urandom_range(0, 3)));
      if (k % 7 == 0) idle(2);
    end
    idle(12);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule